// File: doc/BRIEF.md
# Address-Space-Tagged Translation Cache

This block is a small, fully associative cache of address translations. It holds thirty-two entries, and each entry maps a virtual page to a physical frame. Every entry belongs to one address space, identified by an 8-bit tag, and to one security world, identified by a non-secure bit. An entry can instead be marked global, so that it serves every address space. An entry covers a 4 KB, 64 KB, 1 MB or 16 MB region, which lets a single entry translate a large block.

A lookup request carries a virtual address, the current address-space tag, the security bit, a privilege bit and the access kind. One clock later the block reports hit or miss. On a hit it also gives the translated physical address and an abort flag, which is raised when the stored permissions forbid the access. After a miss the physical address is meaningless, and the requester must refill the entry before it retries.

Refills are written through a separate port. The victim slot follows a round-robin order or comes from a free-running LFSR, as selected. When the lock is enabled, the first eight slots form a reserved region. These slots are written only by an explicit slot number and are never picked as victims. A maintenance port invalidates entries in one cycle. It can clear every entry, every entry of one address space, or every entry that covers one virtual page.

Top module: `tlb_top`

## Requirements
- R1: The table holds 32 entries, and any of them can hold any page. A lookup presented with `lkValid` gives `rspValid` and its result on the next clock. With no request, `rspValid` is low on the next clock.
- R2: A lookup hits only on a valid entry that meets three conditions. Its page matches the virtual address, ignoring the address bits below the entry's page size. Its non-secure bit equals `lkNs`. It is global or its address-space tag equals `lkAsid`. On any other lookup the result is a miss: `rspMiss` high and `rspHit` low.
- R3: An entry written with `fillGlobal`=1 hits under any value of `lkAsid`.
- R4: The `fillSize` code sets the page size: 0 = 4 KB, 1 = 64 KB, 2 = 1 MB, 3 = 16 MB. On a hit, `rspPa` takes the stored frame above the page size and the lookup address below it.
- R5: The permission code `fillAp` works as follows. 0 gives no access. 1 gives privileged read/write and no user access. 2 gives read-only access to both privileged and user requests. 3 gives read/write access to both. The access kind `lkAccess` is 0 for read, 1 for write and 2 or 3 for execute. Execute needs read permission and `fillXn`=0. `rspAbort` is high exactly on a hit whose access is not permitted, and it is never high without `rspHit`.
- R6: With `policyRandom`=0 the refill victim is chosen round-robin. The pointer starts at slot 0 after reset and advances by one after each non-locked refill. It wraps from 31 to the lowest unlocked slot. With the lock enabled, a pointer below 8 jumps to slot 8.
- R7: With `lockEnable`=1, a non-locked refill never writes slots 0 to 7, under either policy. The random policy picks among slots 8 to 31.
- R8: A refill with `fillLock`=1 writes slot `fillSlot` (0 to 7) directly, and that entry hits from the next lookup on.
- R9: Maintenance op 0 (`mntOp`=0) invalidates every entry, locked slots included.
- R10: Maintenance op 1 invalidates the non-global entries whose tag equals `mntAsid`. Global entries and entries of other address spaces are kept.
- R11: Maintenance op 2 invalidates every entry whose page, under its own size, covers `mntVpn`, whatever its tag or security bit. Op 3 does nothing.
- R12: After reset all entries are invalid, all response outputs are low, and the first lookup misses.
- R13: When several entries match a lookup, the lowest-numbered slot supplies the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| lkValid | input | 1 | Lookup request |
| lkVa | input | 32 | Lookup virtual address |
| lkAsid | input | 8 | Current address-space tag |
| lkNs | input | 1 | Current security world (1 = non-secure) |
| lkPriv | input | 1 | 1 = privileged access |
| lkAccess | input | 2 | Access kind: 0 read, 1 write, 2/3 execute |
| rspValid | output | 1 | Lookup result valid |
| rspHit | output | 1 | Lookup hit |
| rspMiss | output | 1 | Lookup miss |
| rspAbort | output | 1 | Hit whose permissions forbid the access |
| rspPa | output | 32 | Translated physical address |
| fillValid | input | 1 | Refill request |
| fillLock | input | 1 | Write the locked slot given by fillSlot |
| fillSlot | input | 3 | Locked slot number |
| fillVpn | input | 20 | Virtual page number (bits 31:12) |
| fillAsid | input | 8 | Address-space tag of the entry |
| fillNs | input | 1 | Non-secure bit of the entry |
| fillGlobal | input | 1 | Entry matches every address space |
| fillSize | input | 2 | Page size code |
| fillPfn | input | 20 | Physical frame number (bits 31:12) |
| fillAp | input | 2 | Permission code |
| fillXn | input | 1 | Execute-never |
| policyRandom | input | 1 | 0 = round-robin, 1 = LFSR victim |
| lockEnable | input | 1 | Reserve slots 0 to 7 |
| mntValid | input | 1 | Maintenance request |
| mntOp | input | 2 | 0 all, 1 by tag, 2 by page, 3 none |
| mntAsid | input | 8 | Tag for maintenance op 1 |
| mntVpn | input | 20 | Page for maintenance op 2 |

## Verification
The hardest state to reach from the ports is a table whose reserved slots must survive a long run of refills under the random policy. There the bench cannot predict which unlocked slot each refill takes. The stimulus first fills all eight reserved slots through the direct-slot path. It then issues fifty LFSR-chosen refills, which is more than the unlocked region can hold, and looks up every reserved page, which must still translate. Page-size overlap is reached by placing a 1 MB entry over a 4 KB entry in a higher slot, which exercises the lowest-slot priority and makes the by-page invalidation remove both.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  localparam int VA_W       = 32;
  localparam int PAGE_SHIFT = 12;
  localparam int VPN_W      = VA_W - PAGE_SHIFT;
  localparam int ASID_W     = 8;
  localparam int ENTRIES    = 32;
  localparam int IDX_W      = $clog2(ENTRIES);

  typedef enum logic [1:0] {SZ_4K, SZ_64K, SZ_1M, SZ_16M} pg_size_e;
  typedef enum logic [1:0] {ACC_READ, ACC_WRITE, ACC_EXEC, ACC_EXEC2} acc_e;
  typedef enum logic [1:0] {MNT_ALL, MNT_ASID, MNT_VA, MNT_NONE} mnt_e;

  typedef struct packed {
    logic              valid;
    logic [VPN_W-1:0]  vpn;
    pg_size_e          size;
    logic [ASID_W-1:0] asid;
    logic              ns;
    logic              glob;
    logic [VPN_W-1:0]  pfn;
    logic [1:0]        ap;
    logic              xn;
  } entry_t;

  typedef struct packed {
    logic             fillEn;
    logic [IDX_W-1:0] fillIdx;
    logic             invAll;
    logic             invAsid;
    logic             invVa;
  } strobe_t;

  // Page-number bits that take part in the compare for a given size
  function automatic logic [VPN_W-1:0] sizeMask(input pg_size_e s);
    case (s)
      SZ_4K:   sizeMask = '1;
      SZ_64K:  sizeMask = {{(VPN_W-4){1'b1}}, 4'h0};
      SZ_1M:   sizeMask = {{(VPN_W-8){1'b1}}, 8'h00};
      default: sizeMask = {{(VPN_W-12){1'b1}}, 12'h000};
    endcase
  endfunction

  function automatic logic permOk(input logic [1:0] ap, input logic xn,
                                  input logic priv, input logic [1:0] acc);
    logic canRead, canWrite;
    canRead  = (ap == 2'b11) || (ap == 2'b10) || (ap == 2'b01 && priv);
    canWrite = (ap == 2'b11) || (ap == 2'b01 && priv);
    case (acc_e'(acc))
      ACC_READ:  permOk = canRead;
      ACC_WRITE: permOk = canWrite;
      default:   permOk = canRead && !xn;
    endcase
  endfunction
endpackage

// File: rtl/tlb_ctrl.sv
module tlb_ctrl
  import tlb_pkg::*;
#(
  parameter int          LOCK_ENTRIES = 8,
  parameter int          LOCK_W       = $clog2(LOCK_ENTRIES),
  parameter int          LFSR_W       = 16,
  parameter logic [15:0] LFSR_TAPS    = 16'hB400,
  parameter logic [15:0] LFSR_SEED    = 16'hACE1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              fillValid,
  input  logic              fillLock,
  input  logic [LOCK_W-1:0] fillSlot,
  input  logic              policyRandom,
  input  logic              lockEnable,
  input  logic              mntValid,
  input  logic [1:0]        mntOp,
  output strobe_t           st
);
  localparam int FREE = ENTRIES - LOCK_ENTRIES;

  logic [IDX_W-1:0]  rrPtr, lo, rrVictim, rndVictim, victim;
  logic [LFSR_W-1:0] lfsr;

  always_comb begin
    lo        = lockEnable ? IDX_W'(LOCK_ENTRIES) : '0;
    rrVictim  = (rrPtr < lo) ? lo : rrPtr;
    rndVictim = lockEnable ? IDX_W'(LOCK_ENTRIES + (int'(lfsr) % FREE))
                           : IDX_W'(int'(lfsr) % ENTRIES);
    victim    = policyRandom ? rndVictim : rrVictim;
  end

  always_comb begin
    st.fillEn  = fillValid;
    st.fillIdx = fillLock ? IDX_W'(fillSlot) : victim;
    st.invAll  = mntValid && (mnt_e'(mntOp) == MNT_ALL);
    st.invAsid = mntValid && (mnt_e'(mntOp) == MNT_ASID);
    st.invVa   = mntValid && (mnt_e'(mntOp) == MNT_VA);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rrPtr <= '0;
      lfsr  <= LFSR_W'(LFSR_SEED);
    end else begin
      lfsr <= {1'b0, lfsr[LFSR_W-1:1]} ^ (lfsr[0] ? LFSR_W'(LFSR_TAPS) : '0);
      if (fillValid && !fillLock && !policyRandom)
        rrPtr <= (rrVictim == IDX_W'(ENTRIES-1)) ? lo : rrVictim + IDX_W'(1);
    end
  end
endmodule

// File: rtl/tlb_datapath.sv
module tlb_datapath
  import tlb_pkg::*;
(
  input  logic                     clk,
  input  logic                     rstN,
  input  strobe_t                  st,
  input  entry_t                   fillEntry,
  input  logic                     lkValid,
  input  logic [VPN_W-1:0]         lkVpn,
  input  logic [PAGE_SHIFT-1:0]    lkOff,
  input  logic [ASID_W-1:0]        lkAsid,
  input  logic                     lkNs,
  input  logic                     lkPriv,
  input  logic [1:0]               lkAccess,
  input  logic [ASID_W-1:0]        mntAsid,
  input  logic [VPN_W-1:0]         mntVpn,
  output logic                     rspValid,
  output logic                     rspHit,
  output logic                     rspMiss,
  output logic                     rspAbort,
  output logic [VA_W-1:0]          rspPa,
  output logic [ENTRIES-1:0]       validVec
);
  entry_t tbl [ENTRIES];

  logic [ENTRIES-1:0] lkMatch, mntMatch;
  logic               hitAny;
  logic [IDX_W-1:0]   sel;
  entry_t             selE;
  logic [VPN_W-1:0]   selMask;
  logic [VA_W-1:0]    paNext;
  logic               accessOk;

  always_comb begin
    for (int i = 0; i < ENTRIES; i++) begin
      lkMatch[i]  = tbl[i].valid
                    && (((tbl[i].vpn ^ lkVpn) & sizeMask(tbl[i].size)) == '0)
                    && (tbl[i].ns == lkNs)
                    && (tbl[i].glob || (tbl[i].asid == lkAsid));
      mntMatch[i] = tbl[i].valid
                    && (((tbl[i].vpn ^ mntVpn) & sizeMask(tbl[i].size)) == '0);
      validVec[i] = tbl[i].valid;
    end
  end

  // Lowest slot wins among multiple matches
  always_comb begin
    hitAny = 1'b0;
    sel    = '0;
    for (int i = ENTRIES-1; i >= 0; i--) begin
      if (lkMatch[i]) begin
        hitAny = 1'b1;
        sel    = IDX_W'(i);
      end
    end
    selE     = tbl[sel];
    selMask  = sizeMask(selE.size);
    paNext   = {(selE.pfn & selMask) | (lkVpn & ~selMask), lkOff};
    accessOk = permOk(selE.ap, selE.xn, lkPriv, lkAccess);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < ENTRIES; i++) tbl[i] <= '0;
    end else begin
      for (int i = 0; i < ENTRIES; i++) begin
        if (st.invAll
            || (st.invAsid && !tbl[i].glob && (tbl[i].asid == mntAsid))
            || (st.invVa && mntMatch[i]))
          tbl[i].valid <= 1'b0;
        if (st.fillEn && (st.fillIdx == IDX_W'(i)))
          tbl[i] <= fillEntry;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rspValid <= 1'b0;
      rspHit   <= 1'b0;
      rspMiss  <= 1'b0;
      rspAbort <= 1'b0;
      rspPa    <= '0;
    end else begin
      rspValid <= lkValid;
      rspHit   <= lkValid && hitAny;
      rspMiss  <= lkValid && !hitAny;
      rspAbort <= lkValid && hitAny && !accessOk;
      rspPa    <= (lkValid && hitAny) ? paNext : '0;
    end
  end
endmodule

// File: rtl/tlb_top.sv
module tlb_top
  import tlb_pkg::*;
#(
  parameter int LOCK_ENTRIES = 8,
  parameter int LOCK_W       = $clog2(LOCK_ENTRIES)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              lkValid,
  input  logic [31:0]       lkVa,
  input  logic [7:0]        lkAsid,
  input  logic              lkNs,
  input  logic              lkPriv,
  input  logic [1:0]        lkAccess,
  output logic              rspValid,
  output logic              rspHit,
  output logic              rspMiss,
  output logic              rspAbort,
  output logic [31:0]       rspPa,
  input  logic              fillValid,
  input  logic              fillLock,
  input  logic [LOCK_W-1:0] fillSlot,
  input  logic [19:0]       fillVpn,
  input  logic [7:0]        fillAsid,
  input  logic              fillNs,
  input  logic              fillGlobal,
  input  logic [1:0]        fillSize,
  input  logic [19:0]       fillPfn,
  input  logic [1:0]        fillAp,
  input  logic              fillXn,
  input  logic              policyRandom,
  input  logic              lockEnable,
  input  logic              mntValid,
  input  logic [1:0]        mntOp,
  input  logic [7:0]        mntAsid,
  input  logic [19:0]       mntVpn
);
  strobe_t            strobes;
  entry_t             fillEntry;
  logic [ENTRIES-1:0] validVec;

  always_comb begin
    fillEntry.valid = 1'b1;
    fillEntry.vpn   = fillVpn;
    fillEntry.size  = pg_size_e'(fillSize);
    fillEntry.asid  = fillAsid;
    fillEntry.ns    = fillNs;
    fillEntry.glob  = fillGlobal;
    fillEntry.pfn   = fillPfn;
    fillEntry.ap    = fillAp;
    fillEntry.xn    = fillXn;
  end

  tlb_ctrl #(.LOCK_ENTRIES(LOCK_ENTRIES), .LOCK_W(LOCK_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .fillValid(fillValid), .fillLock(fillLock),
    .fillSlot(fillSlot), .policyRandom(policyRandom), .lockEnable(lockEnable),
    .mntValid(mntValid), .mntOp(mntOp), .st(strobes)
  );

  tlb_datapath u_dp (
    .clk(clk), .rstN(rstN), .st(strobes), .fillEntry(fillEntry),
    .lkValid(lkValid), .lkVpn(lkVa[VA_W-1:PAGE_SHIFT]), .lkOff(lkVa[PAGE_SHIFT-1:0]),
    .lkAsid(lkAsid), .lkNs(lkNs), .lkPriv(lkPriv), .lkAccess(lkAccess),
    .mntAsid(mntAsid), .mntVpn(mntVpn),
    .rspValid(rspValid), .rspHit(rspHit), .rspMiss(rspMiss),
    .rspAbort(rspAbort), .rspPa(rspPa), .validVec(validVec)
  );
endmodule

// File: rtl/tlb_checker.sv
module tlb_checker
  import tlb_pkg::*;
#(
  parameter int LOCK_ENTRIES = 8
) (
  input logic               clk,
  input logic               rstN,
  input logic               lkValid,
  input logic               rspValid,
  input logic               rspHit,
  input logic               rspAbort,
  input logic               fillLock,
  input logic               lockEnable,
  input strobe_t            st,
  input logic [ENTRIES-1:0] validVec
);
  p_rsp_timing_r1: assert property (@(posedge clk) disable iff (!rstN)
    lkValid |=> rspValid);
  p_rsp_idle_r1: assert property (@(posedge clk) disable iff (!rstN)
    !lkValid |=> !rspValid);
  p_abort_hit_r5: assert property (@(posedge clk) disable iff (!rstN)
    rspAbort |-> rspHit);
  p_victim_unlocked_r7: assert property (@(posedge clk) disable iff (!rstN)
    (st.fillEn && !fillLock && lockEnable) |-> (st.fillIdx >= IDX_W'(LOCK_ENTRIES)));
  p_fill_valid_r8: assert property (@(posedge clk) disable iff (!rstN)
    st.fillEn |=> validVec[$past(st.fillIdx)]);
  p_inv_all_r9: assert property (@(posedge clk) disable iff (!rstN)
    (st.invAll && !st.fillEn) |=> (validVec == '0));
  p_one_maint_r9: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({st.invAll, st.invAsid, st.invVa}));
endmodule

bind tlb_top tlb_checker #(.LOCK_ENTRIES(LOCK_ENTRIES)) u_chk (
  .clk(clk), .rstN(rstN), .lkValid(lkValid), .rspValid(rspValid),
  .rspHit(rspHit), .rspAbort(rspAbort), .fillLock(fillLock),
  .lockEnable(lockEnable), .st(strobes), .validVec(validVec)
);

// File: tb/tb_tlb_top.sv
`timescale 1ns/1ps
module tb_tlb_top;
  logic clk = 1'b0;
  logic rstN;
  logic lkValid; logic [31:0] lkVa; logic [7:0] lkAsid; logic lkNs, lkPriv; logic [1:0] lkAccess;
  logic rspValid, rspHit, rspMiss, rspAbort; logic [31:0] rspPa;
  logic fillValid, fillLock; logic [2:0] fillSlot; logic [19:0] fillVpn; logic [7:0] fillAsid;
  logic fillNs, fillGlobal; logic [1:0] fillSize; logic [19:0] fillPfn; logic [1:0] fillAp; logic fillXn;
  logic policyRandom, lockEnable, mntValid; logic [1:0] mntOp; logic [7:0] mntAsid; logic [19:0] mntVpn;

  int checks = 0;
  int failures = 0;

  always #2.5 clk = ~clk;

  tlb_top dut (.*);

  // Behavioural reference model
  bit mV[32]; logic [31:0] mVa[32]; logic [31:0] mPa[32];
  int mSz[32]; int mAsid[32]; int mAp[32]; bit mNs[32]; bit mG[32]; bit mXn[32];
  int rr = 0;
  bit ovr = 0; bit ovrHit = 0; logic [31:0] ovrPa = 0;

  function automatic int pageBits(int sz);
    return 12 + 4 * sz;
  endfunction

  function automatic bit allowed(int ap, bit xn, bit priv, int acc);
    bit rd, wr;
    rd = (ap == 3) || (ap == 2) || (ap == 1 && priv);
    wr = (ap == 3) || (ap == 1 && priv);
    if (acc == 0) return rd;
    if (acc == 1) return wr;
    return rd && !xn;
  endfunction

  task automatic clearInputs();
    lkValid = 0; fillValid = 0; fillLock = 0; mntValid = 0; ovr = 0;
  endtask

  task automatic cycle(input string tag);
    logic eValid, eHit, eAbort; logic [31:0] ePa; int idx, lo, pb;
    eValid = lkValid; eHit = 0; eAbort = 0; ePa = 0;
    if (lkValid) begin
      for (int i = 0; i < 32; i++) begin
        pb = pageBits(mSz[i]);
        if (!eHit && mV[i] && ((lkVa >> pb) == (mVa[i] >> pb)) && (mNs[i] == lkNs)
            && (mG[i] || mAsid[i] == int'(lkAsid))) begin
          eHit = 1;
          ePa = ((mPa[i] >> pb) << pb) | (lkVa & ((32'h1 << pb) - 32'h1));
          eAbort = !allowed(mAp[i], mXn[i], lkPriv, int'(lkAccess));
        end
      end
      if (ovr) begin eHit = ovrHit; ePa = ovrPa; eAbort = 0; end
    end
    if (mntValid) begin
      for (int i = 0; i < 32; i++) begin
        pb = pageBits(mSz[i]);
        if (mntOp == 2'd0) mV[i] = 0;
        else if (mntOp == 2'd1 && !mG[i] && mAsid[i] == int'(mntAsid)) mV[i] = 0;
        else if (mntOp == 2'd2 && (({mntVpn, 12'h0} >> pb) == (mVa[i] >> pb))) mV[i] = 0;
      end
    end
    if (fillValid) begin
      if (fillLock) idx = int'(fillSlot);
      else if (policyRandom) idx = -1;
      else begin
        lo = lockEnable ? 8 : 0;
        idx = (rr < lo) ? lo : rr;
        rr = (idx == 31) ? lo : idx + 1;
      end
      if (idx >= 0) begin
        mV[idx] = 1; mVa[idx] = {fillVpn, 12'h0}; mPa[idx] = {fillPfn, 12'h0};
        mSz[idx] = int'(fillSize); mAsid[idx] = int'(fillAsid); mAp[idx] = int'(fillAp);
        mNs[idx] = fillNs; mG[idx] = fillGlobal; mXn[idx] = fillXn;
      end
    end
    @(posedge clk);
    @(negedge clk);
    checks++;
    if (rspValid !== eValid || (eValid && (rspHit !== eHit || rspMiss !== !eHit ||
        rspAbort !== eAbort || (eHit && rspPa !== ePa)))) begin
      failures++;
      $display("FAIL %s: actual v=%0b h=%0b m=%0b a=%0b pa=%h expected v=%0b h=%0b a=%0b pa=%h",
               tag, rspValid, rspHit, rspMiss, rspAbort, rspPa, eValid, eHit, eAbort, ePa);
    end
    clearInputs();
  endtask

  task automatic doFill(input logic [31:0] va, input int asid, input bit ns, input bit g,
                        input int sz, input logic [31:0] pa, input int ap, input bit xn,
                        input string tag);
    fillValid = 1; fillLock = 0; fillVpn = va[31:12]; fillAsid = 8'(asid); fillNs = ns;
    fillGlobal = g; fillSize = 2'(sz); fillPfn = pa[31:12]; fillAp = 2'(ap); fillXn = xn;
    cycle(tag);
  endtask

  task automatic doLock(input int slot, input logic [31:0] va, input logic [31:0] pa,
                        input string tag);
    fillValid = 1; fillLock = 1; fillSlot = 3'(slot); fillVpn = va[31:12]; fillAsid = 8'd3;
    fillNs = 0; fillGlobal = 0; fillSize = 2'd0; fillPfn = pa[31:12]; fillAp = 2'd3; fillXn = 0;
    cycle(tag);
  endtask

  task automatic doLook(input logic [31:0] va, input int asid, input bit ns, input bit priv,
                        input int acc, input string tag);
    lkValid = 1; lkVa = va; lkAsid = 8'(asid); lkNs = ns; lkPriv = priv; lkAccess = 2'(acc);
    cycle(tag);
  endtask

  task automatic doMnt(input int op, input int asid, input logic [31:0] va, input string tag);
    mntValid = 1; mntOp = 2'(op); mntAsid = 8'(asid); mntVpn = va[31:12];
    cycle(tag);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    failures++;
    $display("FAIL R1 watchdog: actual=timeout expected=completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    rstN = 0; clearInputs(); lkVa = 0; lkAsid = 0; lkNs = 0; lkPriv = 0; lkAccess = 0;
    fillSlot = 0; fillVpn = 0; fillAsid = 0; fillNs = 0; fillGlobal = 0; fillSize = 0;
    fillPfn = 0; fillAp = 0; fillXn = 0; policyRandom = 0; lockEnable = 0;
    mntOp = 2'd3; mntAsid = 0; mntVpn = 0;
    for (int i = 0; i < 32; i++) mV[i] = 0;
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    checks++;
    if (rspValid !== 0 || rspHit !== 0 || rspMiss !== 0 || rspAbort !== 0) begin
      failures++;
      $display("FAIL R12: actual v=%0b h=%0b m=%0b a=%0b expected all 0",
               rspValid, rspHit, rspMiss, rspAbort);
    end
    doLook(32'h0000_1000, 0, 0, 1, 0, "R12");

    // Mixed sizes, tags, security world
    doFill(32'h0040_0000, 5, 0, 0, 0, 32'h8000_0000, 3, 0, "R8");
    doFill(32'h0123_0000, 5, 0, 0, 1, 32'h9000_0000, 3, 0, "R8");
    doFill(32'h0A00_0000, 7, 0, 1, 3, 32'hC000_0000, 2, 0, "R8");
    doFill(32'h2010_0000, 5, 1, 0, 2, 32'h4550_0000, 1, 1, "R8");
    doLook(32'h0040_0ABC, 5, 0, 0, 0, "R4");
    doLook(32'h0040_0ABC, 6, 0, 0, 0, "R2");
    doLook(32'h0123_F456, 5, 0, 0, 0, "R4");
    doLook(32'h0ABC_DEF0, 99, 0, 0, 0, "R3");
    doLook(32'h0ABC_DEF0, 99, 0, 0, 1, "R5");
    doLook(32'h2018_7654, 5, 1, 1, 0, "R4");
    doLook(32'h2018_7654, 5, 0, 1, 0, "R2");
    doLook(32'h2018_7654, 5, 1, 0, 0, "R5");
    doLook(32'h2018_7654, 5, 1, 1, 2, "R5");
    doLook(32'h2018_7654, 5, 1, 1, 1, "R5");
    doFill(32'h3000_0000, 5, 0, 0, 0, 32'h3300_0000, 0, 0, "R8");
    doLook(32'h3000_0010, 5, 0, 1, 0, "R5");
    doLook(32'h0ABC_DEF0, 7, 0, 0, 2, "R5");
    // Overlap: 1 MB entry above a 4 KB entry
    doFill(32'h0040_0000, 5, 0, 0, 2, 32'hA000_0000, 3, 0, "R8");
    doFill(32'h5000_0000, 9, 0, 0, 0, 32'h5500_0000, 3, 0, "R8");
    doLook(32'h0040_0ABC, 5, 0, 0, 0, "R13");
    doLook(32'h0045_5123, 5, 0, 0, 0, "R13");
    doMnt(3, 0, 32'h0, "R11");
    doLook(32'h0040_0ABC, 5, 0, 0, 0, "R11");
    doMnt(2, 0, 32'h0040_0000, "R11");
    doLook(32'h0040_0ABC, 5, 0, 0, 0, "R11");
    doLook(32'h0045_5123, 5, 0, 0, 0, "R11");
    doMnt(1, 5, 32'h0, "R10");
    doLook(32'h0123_F456, 5, 0, 0, 0, "R10");
    doLook(32'h0ABC_DEF0, 5, 0, 0, 0, "R10");
    doLook(32'h5000_0004, 9, 0, 0, 0, "R10");
    doMnt(0, 0, 32'h0, "R9");
    doLook(32'h0ABC_DEF0, 5, 0, 0, 0, "R9");

    // Capacity and round-robin wrap
    for (int i = 0; i < 32; i++)
      doFill(32'h6000_0000 + i * 32'h1000, 1, 0, 0, 0, 32'hD000_0000 + i * 32'h1000, 3, 0, "R6");
    for (int i = 0; i < 32; i++)
      doLook(32'h6000_0000 + i * 32'h1000 + 32'h44, 1, 0, 0, 0, "R1");
    doFill(32'h7000_0000, 1, 0, 0, 0, 32'hE000_0000, 3, 0, "R6");
    for (int i = 0; i < 32; i++)
      doLook(32'h6000_0000 + i * 32'h1000, 1, 0, 0, 0, "R6");
    doLook(32'h7000_0008, 1, 0, 0, 0, "R6");

    // Locked region under round-robin
    lockEnable = 1;
    doLock(2, 32'h7F00_0000, 32'h1234_5000, "R8");
    doLook(32'h7F00_0123, 3, 0, 0, 0, "R8");
    for (int i = 0; i < 30; i++)
      doFill(32'h6800_0000 + i * 32'h1000, 1, 0, 0, 0, 32'hF000_0000 + i * 32'h1000, 3, 0, "R6");
    doLook(32'h7F00_0123, 3, 0, 0, 0, "R7");

    // Locked region under the random policy
    for (int k = 0; k < 8; k++)
      doLock(k, 32'h7E00_0000 + k * 32'h1000, 32'h2200_0000 + k * 32'h1000, "R8");
    policyRandom = 1;
    for (int i = 0; i < 50; i++)
      doFill(32'h9000_0000 + i * 32'h1000, 1, 0, 0, 0, 32'hB000_0000 + i * 32'h1000, 3, 0, "R7");
    for (int k = 0; k < 8; k++)
      doLook(32'h7E00_0000 + k * 32'h1000 + 32'h10, 3, 0, 0, 0, "R7");
    ovr = 1; ovrHit = 1; ovrPa = 32'hB003_1020;
    lkValid = 1; lkVa = 32'h9003_1020; lkAsid = 8'd1; lkNs = 0; lkPriv = 0; lkAccess = 2'd0;
    cycle("R7");
    policyRandom = 0;
    doMnt(0, 0, 32'h0, "R9");
    doLook(32'h7E00_0010, 3, 0, 0, 0, "R9");
    lockEnable = 0;

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule